// File: doc/BRIEF.md
# Indexed Pointer Address Generator

This block is the address-generation stage in front of a load/store unit. Each request carries a base pointer value, an optional displacement, an access size and a three-bit addressing mode. One clock later the block presents the effective byte address for the memory access. For the modes that modify the pointer, it also presents the updated pointer value and a write-back enable for the register file.

The displacement counts elements, not bytes. It is scaled to bytes by a left shift chosen by the access size. It comes from a 5-bit unsigned immediate or from a full register value, or it is left out. The modes differ on three points: whether the displacement is added or subtracted, whether the access uses the original pointer or the modified one, and whether the modified pointer is written back. All address arithmetic is 32-bit and wraps.

Top module: `ptr_agu`

## Requirements
- R1: Mode code 000 (plain indirect) gives an effective address equal to the base pointer, with the write-back enable low.
- R2: Mode codes 001 (offset add) and 010 (offset subtract) give an address of base plus or minus the scaled displacement, with the write-back enable low.
- R3: Mode codes 011 (pre-increment) and 100 (pre-decrement) give an address of base plus or minus the scaled displacement, raise the write-back enable, and present that same value as the updated pointer.
- R4: Mode codes 101 (post-increment) and 110 (post-decrement) give an address equal to the original base, raise the write-back enable, and present base plus or minus the scaled displacement as the updated pointer.
- R5: Size codes 0, 1, 2 and 3 (byte, half-word, word, double-word) scale the displacement to bytes by a left shift of 0, 1, 2 and 3 bits respectively.
- R6: Displacement select code 1 takes the 5-bit immediate, zero-extended. Codes 2 and 3 take the 32-bit register displacement.
- R7: Displacement select code 0 (no displacement) means one element for the post-modify modes and zero for every other mode.
- R8: Address and pointer arithmetic is modulo 2^32, including the bits of a register displacement that are shifted out by scaling.
- R9: Mode code 111 behaves like plain indirect: the address is the base and the write-back enable stays low.
- R10: Outputs are registered with one cycle of latency. The output valid follows the request valid by one cycle, and the write-back enable is never high without the output valid.
- R11: While reset is high, the output valid, write-back enable, effective address and updated pointer are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| base_ptr | input | 32 | Pointer register value |
| mode | input | 3 | Addressing mode code |
| size | input | 2 | Access size code |
| disp_sel | input | 2 | Displacement source: none, immediate, register |
| disp_imm | input | 5 | Unsigned immediate displacement in elements |
| disp_reg | input | 32 | Register displacement in elements |
| out_valid | output | 1 | Result valid, one cycle after the request |
| eff_addr | output | 32 | Effective byte address for the access |
| wb_ptr | output | 32 | Updated pointer value |
| wb_en | output | 1 | Write the updated pointer back to the register file |

## Verification
The corners that are hardest to reach from the ports are the arithmetic wrap cases. Examples are a decrement that crosses address zero, and a large register displacement whose upper bits fall off during a double-word shift. Uniform random bases and displacements almost never produce either one. The bench therefore drives directed requests with bases near zero and near the top of the space, along with register displacements that have high bits set. It then runs a seeded random stream that spans every mode, size and source combination. That stream includes the missing-displacement default in post-modify modes, and it feeds requests back to back so that each result is checked against the request of the previous cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int ADDR_W = 32;
    localparam int IMM_W  = 5;

    typedef enum logic [2:0] {
        AM_PLAIN    = 3'd0,
        AM_ADD_OFS  = 3'd1,
        AM_SUB_OFS  = 3'd2,
        AM_PRE_INC  = 3'd3,
        AM_PRE_DEC  = 3'd4,
        AM_POST_INC = 3'd5,
        AM_POST_DEC = 3'd6,
        AM_RSVD     = 3'd7
    } am_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        DS_NONE = 2'd0,
        DS_IMM  = 2'd1,
        DS_REG  = 2'd2,
        DS_REGX = 2'd3
    } disp_src_e;

    typedef struct packed {
        logic use_sub;     // subtract displacement instead of add
        logic wb;          // pointer is written back
        logic use_mod;     // access uses the modified value
        logic is_post;     // post-modify mode
    } mode_ctl_t;

    function automatic mode_ctl_t decode_mode(am_mode_e m);
        mode_ctl_t c;
        c = '0;
        case (m)
            AM_ADD_OFS:  begin c.use_mod = 1'b1; end
            AM_SUB_OFS:  begin c.use_mod = 1'b1; c.use_sub = 1'b1; end
            AM_PRE_INC:  begin c.use_mod = 1'b1; c.wb = 1'b1; end
            AM_PRE_DEC:  begin c.use_mod = 1'b1; c.wb = 1'b1; c.use_sub = 1'b1; end
            AM_POST_INC: begin c.is_post = 1'b1; c.wb = 1'b1; end
            AM_POST_DEC: begin c.is_post = 1'b1; c.wb = 1'b1; c.use_sub = 1'b1; end
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/agu_disp_scale.sv
module agu_disp_scale
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = IMM_W
) (
    input  disp_src_e       sel,
    input  logic [IW-1:0]   imm,
    input  logic [AW-1:0]   reg_val,
    input  acc_size_e       size,
    input  logic            is_post,
    output logic [AW-1:0]   disp_bytes
);

    localparam int SH_W = 2;

    logic [AW-1:0] elems;

    always_comb begin
        case (sel)
            DS_IMM:  elems = AW'(imm);
            DS_REG,
            DS_REGX: elems = reg_val;
            default: elems = is_post ? AW'(1) : '0;
        endcase
    end

    logic [SH_W-1:0] sh;
    assign sh = SH_W'(size);
    assign disp_bytes = elems << sh;

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] disp_bytes,
    input  mode_ctl_t     ctl,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] next_ptr,
    output logic          wb
);

    logic [AW-1:0] moved;

    assign moved    = ctl.use_sub ? (base - disp_bytes) : (base + disp_bytes);
    assign addr     = ctl.use_mod ? moved : base;
    assign next_ptr = moved;
    assign wb       = ctl.wb;

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import agu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = IMM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] base_ptr,
    input  logic [2:0]    mode,
    input  logic [1:0]    size,
    input  logic [1:0]    disp_sel,
    input  logic [IW-1:0] disp_imm,
    input  logic [AW-1:0] disp_reg,
    output logic          out_valid,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] wb_ptr,
    output logic          wb_en
);

    mode_ctl_t     ctl;
    logic [AW-1:0] disp_bytes;
    logic [AW-1:0] addr_c;
    logic [AW-1:0] ptr_c;
    logic          wb_c;

    assign ctl = decode_mode(am_mode_e'(mode));

    agu_disp_scale #(.AW(AW), .IW(IW)) u_scale (
        .sel        (disp_src_e'(disp_sel)),
        .imm        (disp_imm),
        .reg_val    (disp_reg),
        .size       (acc_size_e'(size)),
        .is_post    (ctl.is_post),
        .disp_bytes (disp_bytes)
    );

    agu_addr_calc #(.AW(AW)) u_calc (
        .base       (base_ptr),
        .disp_bytes (disp_bytes),
        .ctl        (ctl),
        .addr       (addr_c),
        .next_ptr   (ptr_c),
        .wb         (wb_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            eff_addr  <= '0;
            wb_ptr    <= '0;
        end else begin
            out_valid <= req_valid;
            wb_en     <= req_valid & wb_c;
            if (req_valid) begin
                eff_addr <= addr_c;
                wb_ptr   <= ptr_c;
            end
        end
    end

    // R1
    plain_addr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && !rst && mode == 3'd0) |-> (eff_addr == $past(base_ptr)) && !wb_en);

    // R2
    ofs_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && !rst && (mode == 3'd1 || mode == 3'd2)) |-> out_valid && !wb_en);

    // R3
    pre_wb_match_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && !rst && (mode == 3'd3 || mode == 3'd4)) |-> wb_en && (wb_ptr == eff_addr));

    // R4
    post_addr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && !rst && (mode == 3'd5 || mode == 3'd6)) |-> wb_en && (eff_addr == $past(base_ptr)));

    // R9
    rsvd_plain_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && !rst && mode == 3'd7) |-> (eff_addr == $past(base_ptr)) && !wb_en);

    // R10
    wb_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> out_valid);

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (out_valid == $past(req_valid)));

endmodule

// File: tb/ptr_agu_bench.sv
module ptr_agu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] base_ptr = '0;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [1:0]  disp_sel = '0;
    logic [4:0]  disp_imm = '0;
    logic [31:0] disp_reg = '0;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic [31:0] wb_ptr;
    logic        wb_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ptr_agu u_ptr_agu (
        .clk(clk), .rst(rst), .req_valid(req_valid), .base_ptr(base_ptr),
        .mode(mode), .size(size), .disp_sel(disp_sel), .disp_imm(disp_imm),
        .disp_reg(disp_reg), .out_valid(out_valid), .eff_addr(eff_addr),
        .wb_ptr(wb_ptr), .wb_en(wb_en)
    );

    function automatic logic [31:0] elem_count(logic [2:0] m, logic [1:0] s,
                                               logic [4:0] im, logic [31:0] rg);
        bit post = (m == 3'd5) || (m == 3'd6);
        if (s == 2'd0) return post ? 32'd1 : 32'd0;
        if (s == 2'd1) return {27'd0, im};
        return rg;
    endfunction

    function automatic logic [31:0] byte_disp(logic [31:0] e, logic [1:0] sz);
        logic [63:0] wide;
        wide = {32'd0, e} * (64'd1 << sz);
        return wide[31:0];
    endfunction

    function automatic string tag_of(logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1, 3'd2: return "R2";
            3'd3, 3'd4: return "R3";
            3'd5, 3'd6: return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic run_req(logic [31:0] b, logic [2:0] m, logic [1:0] sz,
                           logic [1:0] ds, logic [4:0] im, logic [31:0] rg, string tag);
        logic [31:0] d, moved, ea, np;
        bit wbx;
        req_valid = 1'b1; base_ptr = b; mode = m; size = sz;
        disp_sel = ds; disp_imm = im; disp_reg = rg;
        d = byte_disp(elem_count(m, ds, im, rg), sz);
        moved = (m == 3'd2 || m == 3'd4 || m == 3'd6) ? b - d : b + d;
        ea = (m >= 3'd1 && m <= 3'd4) ? moved : b;
        np = moved;
        wbx = (m >= 3'd3 && m <= 3'd6);
        @(negedge clk);
        chk(out_valid == 1'b1, {tag, " valid"}, {31'd0, out_valid}, 32'd1);
        chk(eff_addr == ea, {tag, " addr"}, eff_addr, ea);
        chk(wb_en == wbx, {tag, " wb_en"}, {31'd0, wb_en}, {31'd0, wbx});
        if (wbx) chk(wb_ptr == np, {tag, " wb_ptr"}, wb_ptr, np);
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && wb_en == 1'b0, "R10 idle",
            {30'd0, out_valid, wb_en}, 32'd0);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(out_valid == 0 && wb_en == 0, "R11 flags", {30'd0, out_valid, wb_en}, 32'd0);
        chk(eff_addr == 0 && wb_ptr == 0, "R11 addrs", eff_addr | wb_ptr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        idle_check();

        // directed corners
        run_req(32'h4, 3'd0, 2'd1, 2'd1, 5'd3, 32'd0, "R1 plain");
        run_req(32'h100, 3'd1, 2'd2, 2'd1, 5'd31, 32'd0, "R2 R5 R6 add word");
        run_req(32'h100, 3'd2, 2'd1, 2'd1, 5'd4, 32'd0, "R2 sub half");
        run_req(32'h0, 3'd4, 2'd2, 2'd1, 5'd1, 32'd0, "R3 R8 predec wrap");
        run_req(32'hFFFF_FFF8, 3'd3, 2'd3, 2'd1, 5'd1, 32'd0, "R3 R8 preinc wrap");
        run_req(32'h1000, 3'd5, 2'd3, 2'd0, 5'd9, 32'd7, "R4 R7 post default dword");
        run_req(32'h1000, 3'd6, 2'd0, 2'd0, 5'd9, 32'd7, "R4 R7 postdec default byte");
        run_req(32'h1000, 3'd3, 2'd2, 2'd0, 5'd9, 32'd7, "R3 R7 pre no disp");
        run_req(32'h10, 3'd5, 2'd3, 2'd2, 5'd0, 32'hE000_0001, "R4 R6 R8 reg shifted out");
        run_req(32'h10, 3'd1, 2'd0, 2'd3, 5'd0, 32'h0000_0020, "R2 R6 reg alt code");
        run_req(32'h2468, 3'd7, 2'd2, 2'd1, 5'd5, 32'd0, "R9 reserved");
        run_req(32'h80, 3'd1, 2'd0, 2'd1, 5'd2, 32'd0, "R5 byte scale");
        run_req(32'h80, 3'd1, 2'd3, 2'd1, 5'd2, 32'd0, "R5 dword scale");
        idle_check();

        // seeded random, back to back
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] m;
            m = 3'($urandom);
            run_req($urandom, m, 2'($urandom), 2'($urandom), 5'($urandom),
                    (($urandom % 4) == 0) ? $urandom : ($urandom % 64), tag_of(m));
            if (($urandom % 16) == 0) idle_check();
        end
        idle_check();

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule